// File: doc/BRIEF.md
# Cross-Domain Link Register Bridge

This block gives a host processor word access to a small bank of link-layer status and control registers that run on a separate link clock. On the host side it presents four word registers: a data word, a read-address word, a write-address word and a control word whose bit 0 is a completion flag. Writing the read-address word launches a read of a far-side register. When the read completes, the fetched value lands in the data word. A write is staged in two steps. The host first loads the data word and then writes the write-address word, and that address write is what launches the transfer.

Requests cross into the link domain on a toggle handshake with multi-flop synchronizers. Acknowledges come back the same way. The request payload (operation, address and write data) is held steady in host-side registers for as long as a transfer is outstanding. The host polls the completion flag, which one shared mechanism drives for both reads and writes.

The far side is modelled as a five-entry register file, addressed by byte: entry n sits at byte address 0x20 + 4n. Entry 0 is a read-only status word taken from a link input. Entry 1 is an error word: link error pulses set its bits, and writing 1 to a bit clears it. Entries 2, 3 and 4 (control, active, notification) are plain read/write words.

Top module: `link_reg_bridge`

## Requirements
- R1: Host word offsets are fixed: 28 is the data word (read/write), 29 is the read address, 30 is the write address and 31 is control, with the completion flag in bit 0 and all other bits 0. Address words read back the low 8 bits last accepted, zero-extended. Writes to offset 31 and to any other offset have no effect, and other offsets read 0.
- R2: An accepted write to offset 29 launches a far-side read. On completion the data word holds the far register value sampled in the link domain.
- R3: An accepted write to offset 30 launches a far-side write. It carries the value the data word held at the moment of the address write.
- R4: After reset every host word reads 0 and every writable far register is 0. The completion flag becomes 1 when an outstanding transfer completes and stays 1 until the next launch.
- R5: The completion flag reads 0 from the first cycle after a launch until that transfer completes. This lasts at least two host cycles and at most 40 host cycles when the link clock is no slower than 1.5 times the host clock period.
- R6: While a transfer is outstanding, writes to offsets 29 and 30 are ignored: neither address word changes and no far register is touched.
- R7: Far byte address A selects entry (A - 0x20)/4 only when A[1:0] = 0 and 0x20 <= A < 0x34. Any other address reads as 0 and its writes change nothing.
- R8: Far entry 0 (status) reads the link status input and ignores writes. Entries 2 (control), 3 (active) and 4 (notification) store and return written values.
- R9: Far entry 1 (error) sets bits from link error pulses and clears each bit written with 1, so writing all ones clears every flag. A set pulse wins over a clear in the same link cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 5 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| lclk | input | 1 | Link clock |
| lrst_n | input | 1 | Link-domain reset, active low |
| lk_status | input | 32 | Link status value returned by far entry 0 |
| lk_err_set | input | 32 | Per-bit error set pulses for far entry 1 (link clock) |

## Verification
Far reads are tried against each entry kind separately: a changing status input, a stored read/write word, and an error word that the link side sets and that partial and full one-writes clear. A mix-up of entry index, kind or set/clear priority shows up as a wrong data word. Misaligned, below-base and past-end addresses are read and written, and the mapped entries are read afterwards, which separates address decoding from entry selection. An address write issued one cycle after a launch shows whether the pending guard holds. Each poll of the flag in the first cycles after a launch, and the count of polls until it rises, checks the clear-on-launch and the latency bound.

// File: rtl/link_bridge_pkg.sv
`timescale 1ns/1ps
package link_bridge_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } lb_op_e;

  typedef enum logic [1:0] {
    RK_RO  = 2'd0,
    RK_W1C = 2'd1,
    RK_RW  = 2'd2
  } lb_kind_e;

  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_ERROR  = 1;

  // kind of far register cell at a given index
  function automatic lb_kind_e kind_of(input int unsigned idx);
    if (idx == IDX_STATUS) return RK_RO;
    if (idx == IDX_ERROR)  return RK_W1C;
    return RK_RW;
  endfunction

  // byte address falls on a mapped word of the far bank
  function automatic logic far_hit(input logic [31:0] badr,
                                   input logic [31:0] base,
                                   input int unsigned nreg);
    logic [31:0] off;
    off = badr - base;
    return (badr[1:0] == 2'b00) && (badr >= base) && ((off >> 2) < nreg);
  endfunction

  // word index of a byte address inside the far bank
  function automatic logic [31:0] far_index(input logic [31:0] badr,
                                            input logic [31:0] base);
    return (badr - base) >> 2;
  endfunction

endpackage

// File: rtl/lb_sync.sv
`timescale 1ns/1ps
module lb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lb_host_side.sv
`timescale 1ns/1ps
module lb_host_side
  import link_bridge_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int FAR_AW      = 8,
  parameter int OFF_DATA    = 28,
  parameter int OFF_RADR    = 29,
  parameter int OFF_WADR    = 30,
  parameter int OFF_CTRL    = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              req_tgl_o,
  output lb_op_e            req_op_o,
  output logic [FAR_AW-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              ack_tgl_i,
  input  logic [DATA_W-1:0] resp_data_i,
  output logic              launch_o,
  output logic              complete_o,
  output logic              pending_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic [FAR_AW-1:0] rd_addr_o,
  output logic [FAR_AW-1:0] wr_addr_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_RADR = ADDR_W'(OFF_RADR);
  localparam logic [ADDR_W-1:0] A_WADR = ADDR_W'(OFF_WADR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic [DATA_W-1:0] data_q;
  logic [FAR_AW-1:0] rd_addr_q, wr_addr_q;
  logic              pending_q, done_q, req_tgl_q, ack_seen_q, ack_s;
  lb_op_e            req_op_q;
  logic [FAR_AW-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;

  logic wr_data, wr_radr, wr_wadr;
  logic launch_rd, launch_wr, launch, complete;

  assign wr_data   = host_wr && (host_addr == A_DATA);
  assign wr_radr   = host_wr && (host_addr == A_RADR);
  assign wr_wadr   = host_wr && (host_addr == A_WADR);
  assign launch_rd = wr_radr && !pending_q;
  assign launch_wr = wr_wadr && !pending_q;
  assign launch    = launch_rd || launch_wr;

  lb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl_i), .q(ack_s)
  );
  assign complete = ack_s ^ ack_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q      <= '0;
      rd_addr_q   <= '0;
      wr_addr_q   <= '0;
      pending_q   <= 1'b0;
      done_q      <= 1'b0;
      req_tgl_q   <= 1'b0;
      ack_seen_q  <= 1'b0;
      req_op_q    <= OP_READ;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
    end else begin
      ack_seen_q <= ack_s;
      if (launch_rd) begin
        rd_addr_q  <= host_wdata[FAR_AW-1:0];
        req_addr_q <= host_wdata[FAR_AW-1:0];
        req_op_q   <= OP_READ;
      end
      if (launch_wr) begin
        wr_addr_q   <= host_wdata[FAR_AW-1:0];
        req_addr_q  <= host_wdata[FAR_AW-1:0];
        req_wdata_q <= data_q;
        req_op_q    <= OP_WRITE;
      end
      if (launch) begin
        req_tgl_q <= ~req_tgl_q;
        pending_q <= 1'b1;
        done_q    <= 1'b0;
      end
      if (complete) begin
        pending_q <= 1'b0;
        done_q    <= 1'b1;
      end
      if (complete && (req_op_q == OP_READ)) data_q <= resp_data_i;
      else if (wr_data)                      data_q <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == A_DATA)      host_rdata = data_q;
    else if (host_addr == A_RADR) host_rdata = DATA_W'(rd_addr_q);
    else if (host_addr == A_WADR) host_rdata = DATA_W'(wr_addr_q);
    else if (host_addr == A_CTRL) host_rdata = DATA_W'(done_q);
  end

  assign req_tgl_o   = req_tgl_q;
  assign req_op_o    = req_op_q;
  assign req_addr_o  = req_addr_q;
  assign req_wdata_o = req_wdata_q;
  assign launch_o    = launch;
  assign complete_o  = complete;
  assign pending_o   = pending_q;
  assign done_o      = done_q;
  assign data_o      = data_q;
  assign rd_addr_o   = rd_addr_q;
  assign wr_addr_o   = wr_addr_q;
endmodule

// File: rtl/lb_link_side.sv
`timescale 1ns/1ps
module lb_link_side
  import link_bridge_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          FAR_AW      = 8,
  parameter int          NREG        = 5,
  parameter logic [31:0] FAR_BASE    = 32'h20,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_i,
  input  lb_op_e            req_op_i,
  input  logic [FAR_AW-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] lk_status,
  input  logic [DATA_W-1:0] lk_err_set,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              strobe_o
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic req_s, req_seen_q, ack_q, strobe, hit;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] resp_q, rd_val;
  logic [NREG-1:0][DATA_W-1:0] bank_rd;

  lb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl_i), .q(req_s)
  );
  assign strobe = req_s ^ req_seen_q;
  assign hit    = far_hit(32'(req_addr_i), FAR_BASE, NREG);
  assign idx    = IDX_W'(far_index(32'(req_addr_i), FAR_BASE));

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    localparam lb_kind_e K = kind_of(g);
    logic wr_hit;
    assign wr_hit = strobe && (req_op_i == OP_WRITE) && hit && (idx == IDX_W'(g));
    if (K == RK_RO) begin : g_ro
      assign bank_rd[g] = lk_status;
    end else if (K == RK_W1C) begin : g_w1c
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= (cell_q & ~(wr_hit ? req_wdata_i : '0)) | lk_err_set;
      end
      assign bank_rd[g] = cell_q;
    end else begin : g_rw
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cell_q <= '0;
        else if (wr_hit) cell_q <= req_wdata_i;
      end
      assign bank_rd[g] = cell_q;
    end
  end

  assign rd_val = hit ? bank_rd[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
      resp_q     <= '0;
    end else begin
      req_seen_q <= req_s;
      if (strobe) begin
        ack_q <= ~ack_q;
        if (req_op_i == OP_READ) resp_q <= rd_val;
      end
    end
  end

  assign ack_tgl_o   = ack_q;
  assign resp_data_o = resp_q;
  assign strobe_o    = strobe;
endmodule

// File: rtl/link_reg_bridge.sv
`timescale 1ns/1ps
module link_reg_bridge
  import link_bridge_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          DATA_W      = 32,
  parameter int          FAR_AW      = 8,
  parameter int          NREG        = 5,
  parameter logic [31:0] FAR_BASE    = 32'h20,
  parameter int          OFF_DATA    = 28,
  parameter int          OFF_RADR    = 29,
  parameter int          OFF_WADR    = 30,
  parameter int          OFF_CTRL    = 31,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              lclk,
  input  logic              lrst_n,
  input  logic [DATA_W-1:0] lk_status,
  input  logic [DATA_W-1:0] lk_err_set
);
  logic              req_tgl, ack_tgl;
  lb_op_e            req_op;
  logic [FAR_AW-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, resp_data;

  // named internal events for the checker
  logic              ev_launch, ev_complete, ev_pending, ev_done, ev_strobe;
  logic [DATA_W-1:0] ev_data;
  logic [FAR_AW-1:0] ev_rd_addr, ev_wr_addr;

  lb_host_side #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAR_AW(FAR_AW),
    .OFF_DATA(OFF_DATA), .OFF_RADR(OFF_RADR), .OFF_WADR(OFF_WADR),
    .OFF_CTRL(OFF_CTRL), .SYNC_STAGES(SYNC_STAGES)
  ) u_host (
    .clk(hclk), .rst_n(hrst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .req_tgl_o(req_tgl), .req_op_o(req_op), .req_addr_o(req_addr),
    .req_wdata_o(req_wdata), .ack_tgl_i(ack_tgl), .resp_data_i(resp_data),
    .launch_o(ev_launch), .complete_o(ev_complete), .pending_o(ev_pending),
    .done_o(ev_done), .data_o(ev_data), .rd_addr_o(ev_rd_addr),
    .wr_addr_o(ev_wr_addr)
  );

  lb_link_side #(
    .DATA_W(DATA_W), .FAR_AW(FAR_AW), .NREG(NREG), .FAR_BASE(FAR_BASE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_link (
    .clk(lclk), .rst_n(lrst_n),
    .req_tgl_i(req_tgl), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .lk_status(lk_status), .lk_err_set(lk_err_set),
    .ack_tgl_o(ack_tgl), .resp_data_o(resp_data), .strobe_o(ev_strobe)
  );
endmodule

// File: rtl/link_reg_bridge_chk.sv
`timescale 1ns/1ps
module link_reg_bridge_chk #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int FAR_AW   = 8,
  parameter int OFF_DATA = 28,
  parameter int OFF_RADR = 29,
  parameter int OFF_WADR = 30,
  parameter int MAX_LAT  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic              launch,
  input logic              complete,
  input logic              pending,
  input logic              done,
  input logic [DATA_W-1:0] data,
  input logic [FAR_AW-1:0] rd_addr,
  input logic [FAR_AW-1:0] wr_addr
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_cnt <= '0;
    else if (pending) lat_cnt <= lat_cnt + 16'd1;
    else              lat_cnt <= '0;
  end

  a_r5_done_low_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !done);

  a_r4_done_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> done);

  a_r5_pending_excludes_done: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !done);

  a_r6_no_launch_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !launch);

  a_r6_rd_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && host_wr && host_addr == ADDR_W'(OFF_RADR)) |=> $stable(rd_addr));

  a_r6_wr_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && host_wr && host_addr == ADDR_W'(OFF_WADR)) |=> $stable(wr_addr));

  a_r1_data_changes_by_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!complete && !(host_wr && host_addr == ADDR_W'(OFF_DATA))) |=> $stable(data));

  a_r4_launch_complete_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch, complete}));

  a_r5_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lat_cnt < 16'(MAX_LAT));
endmodule

bind link_reg_bridge link_reg_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAR_AW(FAR_AW),
  .OFF_DATA(OFF_DATA), .OFF_RADR(OFF_RADR), .OFF_WADR(OFF_WADR)
) u_chk (
  .clk(hclk), .rst_n(hrst_n), .host_wr(host_wr), .host_addr(host_addr),
  .launch(ev_launch), .complete(ev_complete), .pending(ev_pending),
  .done(ev_done), .data(ev_data), .rd_addr(ev_rd_addr), .wr_addr(ev_wr_addr)
);

// File: tb/link_reg_bridge_bench.sv
`timescale 1ns/1ps
module link_reg_bridge_bench;
  logic        hclk = 1'b0, lclk = 1'b0;
  logic        hrst_n, lrst_n;
  logic        host_wr;
  logic [4:0]  host_addr;
  logic [31:0] host_wdata, host_rdata, lk_status, lk_err_set;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference of the far bank
  logic [31:0] m_ctrl, m_active, m_notify, m_err;
  logic [7:0]  m_wadr;

  always #2.5 hclk = ~hclk;
  always #3.5 lclk = ~lclk;

  link_reg_bridge u_link_reg_bridge (
    .hclk(hclk), .hrst_n(hrst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .lclk(lclk),
    .lrst_n(lrst_n), .lk_status(lk_status), .lk_err_set(lk_err_set)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [31:0] a);
    case (a)
      32'h20:  return lk_status;
      32'h24:  return m_err;
      32'h28:  return m_ctrl;
      32'h2C:  return m_active;
      32'h30:  return m_notify;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [31:0] a, input logic [31:0] v);
    case (a)
      32'h24: m_err    = m_err & ~v;
      32'h28: m_ctrl   = v;
      32'h2C: m_active = v;
      32'h30: m_notify = v;
      default: ;
    endcase
  endfunction

  task automatic hwrite(input int off, input logic [31:0] v);
    @(negedge hclk);
    host_wr = 1'b1; host_addr = 5'(off); host_wdata = v;
    @(negedge hclk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input int off, output logic [31:0] v);
    host_addr = 5'(off);
    #1;
    v = host_rdata;
  endtask

  // poll the flag each host cycle; first two polls after a launch must read 0
  task automatic wait_done(input bit early_chk);
    logic [31:0] v;
    int cyc = 0;
    forever begin
      hread(31, v);
      if (early_chk && cyc < 2) check("R5 flag low after launch", {31'b0, v[0]}, 32'h0);
      if (v[0]) break;
      @(negedge hclk);
      cyc++;
      if (cyc > 40) break;
    end
    check("R5 completion within 40 cycles", {31'b0, cyc <= 40}, 32'h1);
  endtask

  task automatic far_write(input logic [31:0] a, input logic [31:0] v);
    hwrite(28, v);
    hwrite(30, a);
    m_wadr = a[7:0];
    model_write(a, v);
    wait_done(1'b1);
  endtask

  task automatic far_read(input string tag, input logic [31:0] a);
    logic [31:0] v, e;
    hwrite(29, a);
    wait_done(1'b1);
    e = model_read(a);
    hread(28, v);
    check(tag, v, e);
    hread(29, v);
    check("R1 read address readback", v, {24'h0, a[7:0]});
  endtask

  initial begin
    repeat (100000) @(posedge hclk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    hrst_n = 1'b0; lrst_n = 1'b0;
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    lk_status = 32'h1234_5678; lk_err_set = '0;
    m_ctrl = '0; m_active = '0; m_notify = '0; m_err = '0; m_wadr = '0;
    repeat (4) @(negedge hclk);
    hrst_n = 1'b1; lrst_n = 1'b1;
    repeat (2) @(negedge hclk);

    // R4 reset state
    hread(28, v); check("R4 reset data word", v, 32'h0);
    hread(29, v); check("R4 reset read address", v, 32'h0);
    hread(30, v); check("R4 reset write address", v, 32'h0);
    hread(31, v); check("R4 reset flag", v, 32'h0);

    // R1 data word readback, no launch
    hwrite(28, 32'hDEAD_BEEF);
    hread(28, v); check("R1 data word readback", v, 32'hDEAD_BEEF);
    hread(31, v); check("R1 data write launches nothing", v, 32'h0);

    // R3 staged write, R2 read back
    far_write(32'h28, 32'hA5A5_0F0F);
    hread(31, v); check("R4 flag set after write", v, 32'h1);
    hread(30, v); check("R1 write address readback", v, 32'h28);
    far_read("R2 R3 control readback", 32'h28);

    // R8 status follows input, ignores writes
    far_read("R2 status read", 32'h20);
    lk_status = 32'hCAFE_F00D;
    far_read("R8 status follows input", 32'h20);
    far_write(32'h20, 32'h0);
    far_read("R8 status ignores write", 32'h20);

    // R8 other read/write entries
    far_write(32'h2C, 32'h1111_0001);
    far_write(32'h30, 32'h2222_0002);
    far_read("R8 active entry", 32'h2C);
    far_read("R8 notification entry", 32'h30);
    far_read("R8 control untouched", 32'h28);

    // R9 error set and one-to-clear
    @(negedge lclk); lk_err_set = 32'h0000_00F0;
    @(negedge lclk); lk_err_set = 32'h0;
    m_err = 32'h0000_00F0;
    far_read("R9 error set by link", 32'h24);
    far_write(32'h24, 32'h0000_0030);
    far_read("R9 partial clear", 32'h24);
    far_write(32'h24, 32'hFFFF_FFFF);
    far_read("R9 all ones clears", 32'h24);

    // R7 unmapped addresses
    far_read("R7 past end reads 0", 32'h34);
    far_read("R7 misaligned reads 0", 32'h26);
    far_read("R7 below base reads 0", 32'h1C);
    far_write(32'h34, 32'h9999_9999);
    far_write(32'h2E, 32'h7777_7777);
    far_read("R7 stray write leaves active", 32'h2C);
    far_read("R7 stray write leaves notification", 32'h30);

    // R6 address writes while pending are ignored
    hwrite(29, 32'h28);
    hwrite(28, 32'h5555_5555);
    hwrite(30, 32'h2C);
    hread(30, v); check("R6 write address unchanged", v, {24'h0, m_wadr});
    hwrite(29, 32'h30);
    hread(29, v); check("R6 read address unchanged", v, 32'h28);
    wait_done(1'b0);
    hread(28, v); check("R2 pending read result", v, m_ctrl);
    far_read("R6 active not written", 32'h2C);

    // R1 control word and unused offsets
    hwrite(31, 32'h0);
    hread(31, v); check("R1 control write ignored", v, 32'h1);
    hwrite(5, 32'hFFFF_FFFF);
    hread(5, v); check("R1 unused offset reads 0", v, 32'h0);
    hread(31, v); check("R1 unused write launches nothing", v, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule